// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and calendar date from a slow clock enable, nominally 32.768 kHz. A binary prescaler turns the enable pulses into a one-second pulse. That pulse then ripples through a chain of counters: seconds, minutes, hours, day of month, month and year. The day counter wraps at a limit that depends on the month and on whether the year is a leap year. The year is kept as an offset from base year 1998 and spans 100 years.

Software accesses the block through a simple register port. Each field can be read and written, and a busy flag can be read. The busy flag rises one prescaler step before every second boundary and stays up until software pulses the clear input. A reader that sees the flag set knows that a multi-field read may straddle a carry and should be repeated.

The register port is a single-cycle strobe interface with no back-pressure. A write strobe is always taken in the cycle it is presented. Read data is valid in the same cycle as the read strobe. Outside a read, the read data bus is held at zero. The port carries no stream traffic, so there is no valid/ready handshake.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes and hours read 0, day and month read 1, year offset reads 0, busy reads 0 and the prescaler is at 0.
- R2: Seconds advance exactly once per 2^PRESCALE_BITS cycles with `tick_en` high. Cycles with `tick_en` low do not move the prescaler or any field.
- R3: Seconds count 0..59 and wrap to 0 while adding one to minutes. Minutes count 0..59 and wrap to 0 while adding one to hours.
- R4: Hours count 0..23 and wrap to 0 while adding one to the day.
- R5: The day counts from 1 up to the month length and then wraps to 1 while adding one to the month. The month length is 30 for months 4, 6, 9 and 11, is 28 or 29 for month 2, and is 31 for every other month code.
- R6: A year offset y (calendar year 1998+y) is a leap year when y mod 4 equals 2. In a leap year, February has 29 days.
- R7: The month counts 1..12 and wraps to 1 while adding one to the year offset. The year offset counts 0..99 and wraps to 0.
- R8: Busy sets on a `tick_en` cycle in which the prescaler holds 2^PRESCALE_BITS-2, provided no write is taking place. Busy then holds until a cycle with `busy_clr` high clears it. When set and clear occur in the same cycle, set wins.
- R9: A write (`cpu_wr` high) loads the field at `cpu_addr` from the low bits of `cpu_wdata`. The address map is 0 seconds (6 bits), 1 minutes (6), 2 hours (5), 3 day (5), 4 month (4), 5 year offset (7). Every write clears the prescaler, and no count advances in that cycle. Writes to addresses 6 and 7 change no field and leave busy unchanged.
- R10: While `cpu_rd` is high, `cpu_rdata` returns the addressed field zero-extended. Address 6 returns busy in bit 0, and address 7 returns 0. While `cpu_rd` is low, `cpu_rdata` is 0.
- R11: A field written at or above its last legal value (59, 59, 23, month length, 12, 99) wraps to its first value on its next increment and produces a carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, zero when not reading |
| busy_clr | input | 1 | Clears the busy flag |
| busy | output | 1 | Counters about to change |

## Verification
A wrong count or carry in any field shows up on the read port. The bench reads one register per cycle in rotation, so the error is seen within eight cycles of the edge that caused it. A wrong busy flag is compared on its own pin in every cycle. A prescaler that is off by even one step shifts both the busy rise and the second increment by a cycle, and that shift is caught at the next second boundary. A wrong month-length or leap decision is caught at the carry out of the affected day. The bench drives those carries directly with month-end and year-end loads.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 7;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    REG_SEC  = 3'd0,
    REG_MIN  = 3'd1,
    REG_HOUR = 3'd2,
    REG_DAY  = 3'd3,
    REG_MON  = 3'd4,
    REG_YEAR = 3'd5,
    REG_STAT = 3'd6,
    REG_NONE = 3'd7
  } rtc_reg_e;

  typedef struct packed {
    logic [YR_W-1:0]  year;
    logic [MON_W-1:0] month;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hour;
    logic [MIN_W-1:0] minute;
    logic [SEC_W-1:0] second;
  } rtc_time_t;

  function automatic logic [DAY_W-1:0] days_in_month(input logic [MON_W-1:0] m,
                                                     input logic leap);
    logic [DAY_W-1:0] n;
    case (m)
      4'd2:                   n = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
      default:                n = 5'd31;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PB = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          clear,
  output logic          sec_pulse,
  output logic          busy_set,
  output logic [PB-1:0] count
);
  localparam logic [PB-1:0] LAST = {PB{1'b1}};
  localparam logic [PB-1:0] PRE  = {{(PB-1){1'b1}}, 1'b0};

  assign sec_pulse = tick_en && !clear && (count == LAST);
  assign busy_set  = tick_en && !clear && (count == PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W     = 6,
  parameter int FIRST = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] last,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] FIRST_V = W'(FIRST);

  assign carry = inc && (value >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= FIRST_V;
    else if (load) value <= load_val;
    else if (inc)  value <= carry ? FIRST_V : value + 1'b1;
  end
endmodule

// File: rtl/rtc_busy.sv
module rtc_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
(
  input  logic              rd,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  rtc_time_t         now,
  input  logic              busy,
  output logic [5:0]        load,
  output logic [DATA_W-1:0] rdata
);
  for (genvar i = 0; i < 6; i++) begin : g_load
    assign load[i] = wr && (addr == 3'(i));
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (rtc_reg_e'(addr))
        REG_SEC:  rdata = DATA_W'(now.second);
        REG_MIN:  rdata = DATA_W'(now.minute);
        REG_HOUR: rdata = DATA_W'(now.hour);
        REG_DAY:  rdata = DATA_W'(now.day);
        REG_MON:  rdata = DATA_W'(now.month);
        REG_YEAR: rdata = DATA_W'(now.year);
        REG_STAT: rdata = DATA_W'(busy);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESCALE_BITS = 15,
  parameter int YEAR_SPAN     = 100,
  parameter int LEAP_PHASE    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [2:0]  cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        busy_clr,
  output logic        busy
);
  localparam logic [YR_W-1:0]  YEAR_LAST = YR_W'(YEAR_SPAN - 1);
  localparam logic [1:0]       LEAP_SEL  = 2'(LEAP_PHASE);

  logic [PRESCALE_BITS-1:0] psc_cnt;
  logic sec_pulse, busy_set;
  logic [5:0] load;
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year;
  logic [SEC_W-1:0] f_sec;
  logic [MIN_W-1:0] f_min;
  logic [HR_W-1:0]  f_hour;
  logic [DAY_W-1:0] f_day;
  logic [MON_W-1:0] f_mon;
  logic [YR_W-1:0]  f_year;
  logic             leap;
  logic [DAY_W-1:0] day_last;
  rtc_time_t        now;

  assign leap     = (f_year[1:0] == LEAP_SEL);
  assign day_last = days_in_month(f_mon, leap);
  assign now      = '{year: f_year, month: f_mon, day: f_day,
                      hour: f_hour, minute: f_min, second: f_sec};

  rtc_prescaler #(.PB(PRESCALE_BITS)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(cpu_wr),
    .sec_pulse(sec_pulse), .busy_set(busy_set), .count(psc_cnt));

  rtc_field #(.W(SEC_W), .FIRST(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_pulse), .load(load[0]),
    .load_val(cpu_wdata[SEC_W-1:0]), .last(SEC_W'(59)),
    .value(f_sec), .carry(c_sec));

  rtc_field #(.W(MIN_W), .FIRST(0)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .load(load[1]),
    .load_val(cpu_wdata[MIN_W-1:0]), .last(MIN_W'(59)),
    .value(f_min), .carry(c_min));

  rtc_field #(.W(HR_W), .FIRST(0)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .load(load[2]),
    .load_val(cpu_wdata[HR_W-1:0]), .last(HR_W'(23)),
    .value(f_hour), .carry(c_hour));

  rtc_field #(.W(DAY_W), .FIRST(1)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(load[3]),
    .load_val(cpu_wdata[DAY_W-1:0]), .last(day_last),
    .value(f_day), .carry(c_day));

  rtc_field #(.W(MON_W), .FIRST(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc(c_day), .load(load[4]),
    .load_val(cpu_wdata[MON_W-1:0]), .last(MON_W'(12)),
    .value(f_mon), .carry(c_mon));

  rtc_field #(.W(YR_W), .FIRST(0)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_mon), .load(load[5]),
    .load_val(cpu_wdata[YR_W-1:0]), .last(YEAR_LAST),
    .value(f_year), .carry(c_year));

  rtc_busy u_busy (
    .clk(clk), .rst_n(rst_n), .set(busy_set), .clr(busy_clr), .flag(busy));

  rtc_regif u_regif (
    .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr), .now(now), .busy(busy),
    .load(load), .rdata(cpu_rdata));
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker #(
  parameter int PB = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          cpu_wr,
  input logic          busy_clr,
  input logic          busy,
  input logic [5:0]    sec,
  input logic [5:0]    min,
  input logic [4:0]    day,
  input logic [PB-1:0] psc
);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !busy_clr |=> busy);

  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !tick_en |=> !busy);

  assert_sec_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cpu_wr |=> $stable(sec));

  assert_psc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> psc == '0);

  assert_min_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr && sec < 6'd59 |=> $stable(min));

  assert_day_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr && day != 5'd0 |=> day != 5'd0);
endmodule

bind rtc_calendar rtc_calendar_checker #(.PB(PRESCALE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_wr(cpu_wr),
  .busy_clr(busy_clr), .busy(busy), .sec(f_sec), .min(f_min),
  .day(f_day), .psc(psc_cnt));

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  localparam int PB = 4;
  localparam int P  = 1 << PB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       cpu_rd = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [2:0] cpu_addr = 3'd0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       busy_clr = 1'b0;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int rr = 0;

  // reference state
  int m_psc, m_sec, m_min, m_hr, m_day, m_mon, m_yr;
  bit m_busy;

  always #4 clk = ~clk;

  rtc_calendar #(.PRESCALE_BITS(PB)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .busy_clr(busy_clr), .busy(busy));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mlen(input int mo, input int y);
    if (mo == 2) return (y % 4 == 2) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int model_read(input bit rd, input int a);
    if (!rd) return 0;
    case (a)
      0: return m_sec;
      1: return m_min;
      2: return m_hr;
      3: return m_day;
      4: return m_mon;
      5: return m_yr;
      6: return int'(m_busy);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step(input bit tick, input bit wr, input int a,
                            input int wd, input bit clr);
    bit bset, spulse;
    bset   = tick && !wr && (m_psc == P - 2);
    spulse = tick && !wr && (m_psc == P - 1);
    if (wr) begin
      m_psc = 0;
      case (a)
        0: m_sec = wd % 64;
        1: m_min = wd % 64;
        2: m_hr  = wd % 32;
        3: m_day = wd % 32;
        4: m_mon = wd % 16;
        5: m_yr  = wd % 128;
        default: ;
      endcase
    end else if (tick) m_psc = (m_psc + 1) % P;
    if (spulse) begin
      if (m_sec >= 59) begin
        m_sec = 0;
        if (m_min >= 59) begin
          m_min = 0;
          if (m_hr >= 23) begin
            m_hr = 0;
            if (m_day >= mlen(m_mon, m_yr)) begin
              m_day = 1;
              if (m_mon >= 12) begin
                m_mon = 1;
                m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
              end else m_mon++;
            end else m_day++;
          end else m_hr++;
        end else m_min++;
      end else m_sec++;
    end
    if (bset) m_busy = 1'b1;
    else if (clr) m_busy = 1'b0;
  endtask

  // one clock: drive, compare, edge, advance reference
  task automatic cyc(input bit tick, input bit wr, input bit rd,
                     input int a, input int wd, input bit clr);
    tick_en = tick; cpu_wr = wr; cpu_rd = rd;
    cpu_addr = 3'(a); cpu_wdata = 8'(wd); busy_clr = clr;
    #1;
    check(rd ? tag_of(a) : "R10", int'(cpu_rdata), model_read(rd, a));
    check("R8 busy pin", int'(busy), int'(m_busy));
    @(posedge clk);
    model_step(tick, wr, a, wd, clr);
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      cyc(!(gaps && (i % 3 == 2)), 1'b0, 1'b1, rr % 8, 0, 1'b0);
      rr++;
    end
  endtask

  task automatic wr_reg(input int a, input int v);
    cyc(1'b1, 1'b1, 1'b0, a, v, 1'b0);
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = 3'(a); tick_en = 1'b0; busy_clr = 1'b0;
    #1;
    check(tag, int'(cpu_rdata), exp);
    cyc(1'b0, 1'b0, 1'b1, a, 0, 1'b0);
  endtask

  task automatic set_time(input int s, input int mi, input int h,
                          input int d, input int mo, input int y);
    wr_reg(0, s); wr_reg(1, mi); wr_reg(2, h);
    wr_reg(3, d); wr_reg(4, mo); wr_reg(5, y);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_psc = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
    m_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    expect_rd(0, 0, "R1 sec"); expect_rd(1, 0, "R1 min"); expect_rd(2, 0, "R1 hour");
    expect_rd(3, 1, "R1 day"); expect_rd(4, 1, "R1 month"); expect_rd(5, 0, "R1 year");
    expect_rd(6, 0, "R1 busy");

    // R2: exactly P enable cycles per second, idle cycles ignored
    for (int i = 0; i < P - 1; i++) cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
    expect_rd(0, 0, "R2 before last tick");
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    expect_rd(0, 1, "R2 after P ticks");
    run(40 * P, 1'b1);

    // R8 clear, and set wins over clear
    cyc(1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    expect_rd(6, 0, "R8 cleared");
    while (m_psc != P - 2) cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b1);
    expect_rd(6, 1, "R8 set beats clear");

    // R9: write to status/unused addresses changes nothing
    wr_reg(6, 0); wr_reg(7, 8'hff);
    expect_rd(6, 1, "R9 status write ignored");

    // R7 full year rollover
    set_time(58, 59, 23, 31, 12, 99);
    run(3 * P, 1'b0);
    expect_rd(5, 0, "R7 year wrap"); expect_rd(4, 1, "R7 month wrap");

    // R6 leap February (offset 2 = year 2000)
    set_time(59, 59, 23, 28, 2, 2);
    run(P, 1'b0);
    expect_rd(3, 29, "R6 leap day 29");
    set_time(59, 59, 23, 29, 2, 2);
    run(P, 1'b0);
    expect_rd(4, 3, "R6 leap Feb ends at 29");
    // non-leap offset 3
    set_time(59, 59, 23, 28, 2, 3);
    run(P, 1'b0);
    expect_rd(3, 1, "R5 non-leap Feb ends at 28");
    // 30-day month
    set_time(59, 59, 23, 30, 4, 10);
    run(P, 1'b0);
    expect_rd(4, 5, "R5 April ends at 30");
    set_time(59, 59, 23, 30, 5, 10);
    run(P, 1'b0);
    expect_rd(3, 31, "R5 May has 31");

    // R11 out-of-range written seconds
    set_time(63, 5, 4, 3, 2, 1);
    run(P, 1'b0);
    expect_rd(0, 0, "R11 sec wrap from 63"); expect_rd(1, 6, "R11 carry");

    // R9: mid-second write restarts prescaler
    run(P / 2, 1'b0);
    wr_reg(1, 20);
    for (int i = 0; i < P - 1; i++) cyc(1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    expect_rd(0, 0, "R9 prescaler restarted");
    run(3 * P, 1'b1);

    // R10 read gating
    cyc(1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    expect_rd(7, 0, "R10 unused address");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule